// File: doc/BRIEF.md
# ADC Calibration Launch Scheduler

This block decides when the converter runs its calibration. A calibration is launched for one of two reasons: software asks for one, or the automatic recalibration period has elapsed while automatic recalibration is switched on. The period is measured in cycles of a slow 32 kHz low-power clock. That clock arrives as a raw level, and the block brings it into the ADC clock domain itself. The long intervals therefore drift with the accuracy of the slow oscillator.

A launch never happens while the converter is busy. Once a launch is pending, the block waits for a programmable run of consecutive activity-free ADC clocks. It then emits a one-cycle start strobe to the calibration engine and waits for the engine's done pulse. It reports three things: a pending-request flag that hardware clears, an in-progress flag and a calibration-done flag.

A request that arrives while a calibration is already running is absorbed into that calibration. A periodic expiry that coincides with a software request produces a single launch.

Top module: `cal_sched`

## Requirements
- R1: After reset, `req_pend`, `cal_start`, `cal_active` and `cal_ready` are all 0.
- R2: A cycle with `req_set` high sets `req_pend`. With `adc_busy` low, `cal_start` pulses exactly N clocks after the edge that sampled the request, where N is 2, 4, 8 or 16 for `idle_sel` codes 00, 01, 10 and 11. `req_pend` is cleared at the same edge.
- R3: An edge that samples `adc_busy` high restarts the idle run. The launch then comes N idle clocks after that edge, and `cal_start` is never high in the cycle after `adc_busy` was high.
- R4: `cal_start` is high for exactly one cycle. From that edge, `cal_active` is 1 and `cal_ready` is 0 until an edge samples `cal_done`. After that edge, `cal_active` is 0 and `cal_ready` is 1.
- R5: A software request or a period expiry that occurs while `cal_active` is 1 is dropped. It does not set `req_pend` and it causes no later launch.
- R6: With `auto_en` high, calibrations are launched periodically. Consecutive launches are exactly P slow-clock rising edges apart, where P is `TICKS_PER_SEC` times 1, 64, 1024 or 4096 for `rate_sel` codes 00, 01, 10 and 11. With `auto_en` low, no periodic launch occurs.
- R7: Any change of `rate_sel` restarts the period count from zero. The next expiry is therefore one full new period after the change.
- R8: A software request sampled at the same edge as a period expiry yields one launch, not two.
- R9: The slow clock level passes through a two-flop synchroniser. Exactly one internal tick is produced for each rising edge of `lp_clk_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_clk_lvl | input | 1 | Raw level of the 32 kHz low-power clock |
| adc_busy | input | 1 | Converter activity in this cycle |
| auto_en | input | 1 | Automatic recalibration enable |
| rate_sel | input | 2 | Recalibration period code |
| idle_sel | input | 2 | Required idle-run length code |
| req_set | input | 1 | Software write of 1 to the request bit |
| cal_done | input | 1 | Done pulse from the calibration engine |
| cal_start | output | 1 | One-cycle launch strobe to the engine |
| req_pend | output | 1 | Request bit readback, cleared at launch |
| cal_active | output | 1 | Calibration in progress |
| cal_ready | output | 1 | Calibration has finished |

## Verification
Software requests are issued with random idle-length codes. Some requests see no activity at all, and these confirm the exact launch delay for each code. In others, a single busy cycle falls at a random point in the idle run, including the last idle slot, and these show that the run restarts instead of continuing. Periodic launches are timed for three rate codes, which separates the period lengths and shows that the enable gates them. Three directed cases cover the remaining behaviour: a mid-period rate change, a request made during a running calibration, and a request placed on the exact expiry edge. Together they tell a restart apart from a continued count, and a merged launch apart from a doubled or queued one.

// File: rtl/cal_sched_pkg.sv
package cal_sched_pkg;
  localparam int unsigned RATE_W       = 2;
  localparam int unsigned IDLE_SEL_W   = 2;
  localparam int unsigned LONGEST_SECS = 4096;
  localparam int unsigned MAX_IDLE     = 16;

  // seconds between automatic recalibrations for each rate code
  function automatic int unsigned period_secs(input logic [RATE_W-1:0] code);
    case (code)
      2'd0:    period_secs = 1;
      2'd1:    period_secs = 64;
      2'd2:    period_secs = 1024;
      default: period_secs = LONGEST_SECS;
    endcase
  endfunction

  // consecutive idle clocks required before a launch
  function automatic int unsigned idle_need(input logic [IDLE_SEL_W-1:0] code);
    idle_need = 2 << code;
  endfunction
endpackage

// File: rtl/cal_tick_sync.sv
module cal_tick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic tick
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], lvl_in};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign tick = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R9: one tick per rising edge, never two in a row
  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/cal_period_timer.sv
module cal_period_timer
  import cal_sched_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              auto_en,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              expire
);
  localparam int unsigned MAX_TICKS = LONGEST_SECS * TICKS_PER_SEC;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS);

  logic [CNT_W-1:0]  cnt_q, cnt_d, last_val;
  logic [RATE_W-1:0] rate_q;
  logic              restart, at_last, exp_q, exp_d;

  always_comb begin
    last_val = CNT_W'(period_secs(rate_sel) * TICKS_PER_SEC - 1);
    restart  = (rate_sel != rate_q);
    at_last  = (cnt_q == last_val);
    exp_d    = auto_en & ~restart & tick & at_last;
    cnt_d    = cnt_q;
    if (!auto_en || restart)
      cnt_d = '0;
    else if (tick)
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= '0;
      exp_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rate_q <= rate_sel;
      exp_q  <= exp_d;
    end
  end

  assign expire = exp_q;

  // R6: an expiry only follows a cycle with the enable high
  assert_expire_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(auto_en));
  // R7: a rate change suppresses expiry in the following cycle
  assert_rate_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel != rate_q) |=> !expire);
endmodule

// File: rtl/cal_idle_gate.sv
module cal_idle_gate
  import cal_sched_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm,
  input  logic                  busy,
  input  logic [IDLE_SEL_W-1:0] idle_sel,
  output logic                  launch
);
  localparam int unsigned IDLE_W = $clog2(MAX_IDLE);

  logic [IDLE_W-1:0] run_q, run_d, need_m1;

  always_comb begin
    need_m1 = IDLE_W'(idle_need(idle_sel) - 1);
    launch  = arm & ~busy & (run_q == need_m1);
    run_d   = run_q;
    if (!arm || busy || launch)
      run_d = '0;
    else
      run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // R3: the idle run is empty after any busy cycle
  assert_busy_clears_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (run_q == '0));
endmodule

// File: rtl/cal_sched.sv
module cal_sched
  import cal_sched_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lp_clk_lvl,
  input  logic                  adc_busy,
  input  logic                  auto_en,
  input  logic [RATE_W-1:0]     rate_sel,
  input  logic [IDLE_SEL_W-1:0] idle_sel,
  input  logic                  req_set,
  input  logic                  cal_done,
  output logic                  cal_start,
  output logic                  req_pend,
  output logic                  cal_active,
  output logic                  cal_ready
);
  logic slow_tick, expire, launch, arm;
  logic pend_q, pend_d, act_q, act_d, rdy_q, rdy_d, strobe_q;

  cal_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lvl_in(lp_clk_lvl), .tick(slow_tick));

  cal_period_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .auto_en(auto_en),
    .rate_sel(rate_sel), .expire(expire));

  assign arm = pend_q & ~act_q;

  cal_idle_gate u_gate (
    .clk(clk), .rst_n(rst_n), .arm(arm), .busy(adc_busy),
    .idle_sel(idle_sel), .launch(launch));

  // both sources fold into one pending bit; dropped while a cycle runs
  always_comb begin
    pend_d = pend_q;
    if (launch)
      pend_d = 1'b0;
    else if ((req_set | expire) & ~act_q)
      pend_d = 1'b1;

    act_d = act_q;
    if (launch)        act_d = 1'b1;
    else if (cal_done) act_d = 1'b0;

    rdy_d = rdy_q;
    if (launch)                 rdy_d = 1'b0;
    else if (cal_done && act_q) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      act_q    <= 1'b0;
      rdy_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      act_q    <= act_d;
      rdy_q    <= rdy_d;
      strobe_q <= launch;
    end
  end

  assign cal_start  = strobe_q;
  assign req_pend   = pend_q;
  assign cal_active = act_q;
  assign cal_ready  = rdy_q;

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);
  assert_start_sets_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> (cal_active && !cal_ready));
  assert_done_sets_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_active && cal_done) |=> (cal_ready && !cal_active));
  assert_launch_clears_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> !req_pend);
  assert_busy_blocks_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_busy |=> !cal_start);
  assert_merge_while_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_active |=> !req_pend);
endmodule

// File: tb/test_cal_sched.sv
module test_cal_sched;
  localparam int unsigned TPS      = 1;
  localparam int          TICK_LEN = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lp_clk_lvl = 1'b0;
  logic       adc_busy = 1'b0;
  logic       auto_en = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic [1:0] idle_sel = 2'd0;
  logic       req_set = 1'b0;
  logic       cal_done = 1'b0;
  logic       cal_start, req_pend, cal_active, cal_ready;

  int n_vec = 0, n_bad = 0;
  int edge_cnt = 0, starts = 0, last_start = 0;
  int done_dly = 2, done_cnt = 0, lp_cnt = 0;

  cal_sched #(.TICKS_PER_SEC(TPS)) i_cal_sched (
    .clk(clk), .rst_n(rst_n), .lp_clk_lvl(lp_clk_lvl), .adc_busy(adc_busy),
    .auto_en(auto_en), .rate_sel(rate_sel), .idle_sel(idle_sel),
    .req_set(req_set), .cal_done(cal_done), .cal_start(cal_start),
    .req_pend(req_pend), .cal_active(cal_active), .cal_ready(cal_ready));

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  // slow clock: rising edge every TICK_LEN fast clocks
  always @(negedge clk) begin
    if (lp_cnt == TICK_LEN/2 - 1) begin lp_cnt = 0; lp_clk_lvl = ~lp_clk_lvl; end
    else lp_cnt = lp_cnt + 1;
  end

  // start monitor and calibration engine model
  always @(negedge clk) begin
    cal_done = 1'b0;
    if (cal_start) begin
      starts = starts + 1; last_start = edge_cnt; done_cnt = done_dly;
    end else if (done_cnt > 0) begin
      done_cnt = done_cnt - 1;
      if (done_cnt == 0) cal_done = 1'b1;
    end
  end

  function automatic int need_of(input logic [1:0] s); return 2 << s; endfunction
  function automatic int secs_of(input logic [1:0] r);
    case (r) 2'd0: return 1; 2'd1: return 64; 2'd2: return 1024; default: return 4096; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && (cal_active || req_pend); i++) cyc(1);
    cyc(2);
  endtask

  // R2 / R3 / R4: software request with optional single busy cycle
  task automatic sw_trial(input logic [1:0] sel, input int busy_at);
    int need, exp_d, e0, obs;
    bit seen;
    need = need_of(sel);
    idle_sel = sel;
    done_dly = 1 + int'($urandom % 5);
    wait_idle();
    req_set = 1'b1; adc_busy = 1'b0;
    cyc(1);
    req_set = 1'b0;
    chk(req_pend == 1'b1, "R2 req_pend set", req_pend, 1);
    e0 = edge_cnt;
    exp_d = (busy_at == 0) ? need : busy_at + need;
    seen = 1'b0;
    for (int k = 1; k <= 60 && !seen; k++) begin
      adc_busy = (k == busy_at);
      cyc(1);
      seen = cal_start;
    end
    adc_busy = 1'b0;
    obs = seen ? (edge_cnt - e0) : -1;
    chk(obs == exp_d, (busy_at == 0) ? "R2 launch delay" : "R3 idle restart", obs, exp_d);
    chk(cal_active && !cal_ready && !req_pend, "R4 state at launch",
        {cal_active, cal_ready, req_pend}, 3'b100);
    cyc(1);
    chk(!cal_start, "R4 strobe width", cal_start, 0);
    for (int i = 0; i < 20 && cal_active; i++) cyc(1);
    chk(cal_ready && !cal_active, "R4 ready after done", {cal_ready, cal_active}, 2'b10);
  endtask

  // R6: spacing of consecutive periodic launches
  task automatic measure(input logic [1:0] r);
    int s0, t1, lim;
    idle_sel = 2'd0; done_dly = 2;
    rate_sel = r; auto_en = 1'b1;
    s0 = starts;
    lim = secs_of(r) * TICK_LEN * 3 + 200;
    for (int i = 0; i < lim && starts < s0 + 1; i++) cyc(1);
    t1 = last_start;
    for (int i = 0; i < lim && starts < s0 + 2; i++) cyc(1);
    chk(starts == s0 + 2 && (last_start - t1) == secs_of(r) * TICK_LEN,
        "R6 period spacing", last_start - t1, secs_of(r) * TICK_LEN);
    auto_en = 1'b0;
    wait_idle();
  endtask

  initial begin
    int s0, s_edge, t0;
    bit seen;
    void'($urandom(32'd20240611));
    cyc(3);
    chk({req_pend, cal_start, cal_active, cal_ready} == 4'b0, "R1 reset state",
        {req_pend, cal_start, cal_active, cal_ready}, 0);
    rst_n = 1'b1;
    cyc(2);
    chk({req_pend, cal_start, cal_active, cal_ready} == 4'b0, "R1 after release",
        {req_pend, cal_start, cal_active, cal_ready}, 0);

    // directed corners then random mix
    sw_trial(2'd0, 0);
    sw_trial(2'd3, 0);
    sw_trial(2'd3, 16);
    sw_trial(2'd1, 1);
    for (int t = 0; t < 40; t++) begin
      logic [1:0] s;
      int b;
      s = 2'($urandom % 4);
      b = ($urandom % 2) ? 1 + int'($urandom % need_of(s)) : 0;
      sw_trial(s, b);
    end

    // R5: request during a running calibration is absorbed
    idle_sel = 2'd0; done_dly = 10;
    wait_idle();
    req_set = 1'b1; cyc(1); req_set = 1'b0;
    for (int i = 0; i < 20 && !cal_active; i++) cyc(1);
    s0 = starts;
    cyc(2);
    req_set = 1'b1; cyc(1); req_set = 1'b0;
    chk(!req_pend, "R5 request dropped", req_pend, 0);
    cyc(60);
    chk(starts == s0 && !req_pend, "R5 no queued launch", starts - s0, 0);

    // R6: no periodic launches while disabled
    auto_en = 1'b0; rate_sel = 2'd0;
    s0 = starts;
    cyc(500);
    chk(starts == s0, "R6 disabled", starts - s0, 0);

    measure(2'd0);
    measure(2'd1);
    measure(2'd2);

    // R7: rate change restarts the period count
    idle_sel = 2'd0; done_dly = 2;
    rate_sel = 2'd2; auto_en = 1'b1;
    s0 = starts;
    cyc(300);
    chk(starts == s0, "R7 long rate quiet", starts - s0, 0);
    rate_sel = 2'd0;
    t0 = edge_cnt;
    seen = 1'b0;
    for (int i = 0; i < 60 && !seen; i++) begin cyc(1); seen = (starts != s0); end
    chk(seen && (last_start - t0) >= 3 && (last_start - t0) <= 26, "R7 restart",
        last_start - t0, 26);
    auto_en = 1'b0;
    wait_idle();

    // R8: request on the exact expiry edge launches once
    rate_sel = 2'd0; idle_sel = 2'd0; done_dly = 2; auto_en = 1'b1;
    s0 = starts;
    for (int i = 0; i < 200 && starts == s0; i++) cyc(1);
    s_edge = last_start;
    s0 = starts;
    for (int i = 0; i < 100 && edge_cnt < s_edge + 17; i++) cyc(1);
    req_set = 1'b1; cyc(1); req_set = 1'b0;
    for (int i = 0; i < 100 && edge_cnt < s_edge + 39; i++) cyc(1);
    chk(starts == s0 + 1 && last_start == s_edge + 20, "R8 single launch",
        starts - s0, 1);
    auto_en = 1'b0;
    wait_idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(190000 * 5);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", edge_cnt, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule